// File: doc/BRIEF.md
# Vector Block Context Tracker

This block keeps the processor-side record of how far execution has got through a variable-length vector instruction block. A two-bit status field shows the decode state machine directly. Status 0 is plain scalar execution. Status 1 means the header fields have been captured. Status 2 means the vector-length section has been decoded. Status 3 means the predicate and register sections are loaded and opcodes may run. Next to the status sits an opcode pointer, counted in 16-bit units, which plays the role of a program counter inside the block. Pointer value 0 is the first opcode of the block.

The instruction decoder reports its progress through single-cycle event pulses. The execution pipeline advances the pointer by the size of each opcode. A control-register port lets software read the whole register and write a new pointer value. A write is accepted only when the block is fully decoded and the value lies inside the opcode region. Any other write raises an illegal-instruction flag and changes nothing. A trap return may roll status back from 3 to 2 so that the sections are decoded again, and the pointer is kept through this.

All outputs come from registers. Every effect of an input appears at the outputs one clock after the edge that samples it.

Top module: `vblk_ctx`

## Requirements
- R1: A synchronous reset drives status to 0, the pointer to 0, read data to 0 and the illegal flag to 0.
- R2: In status 0 a start pulse arms the block, and a later header pulse then moves status to 1. From status 1 a length pulse moves status to 2. From status 2 a context pulse moves status to 3. Each move appears one clock after its pulse.
- R3: Decode events that arrive out of order are ignored. Examples are a header pulse without an earlier start pulse, or a context pulse while status is 1.
- R4: In status 3, outside a trap, an advance adds step_i to the pointer. If the sum is greater than or equal to blk_len_i, status becomes 0 and the pointer becomes 0.
- R5: A done pulse returns status to 0 and the pointer to 0 from any status. It has priority over every other input in the same cycle.
- R6: An immediate-form write (csr_imm_i=1) uses only the low IMM_W bits of csr_wdata_i, zero-extended (IMM_W defaults to 5). In status 3, if that value is below blk_len_i, it becomes the pointer and status stays 3.
- R7: A register-form write (csr_imm_i=0) takes the whole csr_wdata_i as the new pointer. It is accepted only if that full value is below blk_len_i, so any set bit above the pointer width makes it illegal.
- R8: A write while status is not 3, or a write of an out-of-range value, sets illegal_o for one cycle. Status and pointer are left unchanged.
- R9: A read loads csr_rdata_o with the full register: status in bits [1:0] and the pointer in bits [XLEN-1:2]. The value is the one from before any write in the same cycle.
- R10: A trap return while status is 3 moves status to 2 and keeps the pointer. A later context pulse brings status back to 3 with the same pointer.
- R11: Between trap entry and trap return, advance pulses leave the pointer unchanged.
- R12: When a write and an advance arrive in the same cycle, the write decides the pointer and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_i | input | 1 | Start of a valid vector block seen |
| ev_hdr_i | input | 1 | Header fields captured |
| ev_len_i | input | 1 | Vector-length section decoded |
| ev_ctx_i | input | 1 | Predicate and register sections decoded |
| ev_done_i | input | 1 | Block finished |
| adv_i | input | 1 | Opcode retired; advance the pointer |
| step_i | input | STEP_W | Advance amount in 16-bit units |
| blk_len_i | input | PTR_W | Opcode region length in 16-bit units |
| trap_enter_i | input | 1 | Trap taken |
| trap_ret_i | input | 1 | Return from trap |
| csr_rd_i | input | 1 | Register read |
| csr_wr_i | input | 1 | Register write |
| csr_imm_i | input | 1 | 1 = immediate form, 0 = register form |
| csr_wdata_i | input | XLEN | Write value |
| status_o | output | 2 | Current status |
| opptr_o | output | PTR_W | Opcode pointer |
| csr_rdata_o | output | XLEN | Read data |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
A pointer write and a sequential advance can land in the same cycle, and so can a write and a done pulse. The bench drives both pairs together. In the first case it expects the written value to win over the sum. In the second case it expects the done pulse to clear everything, with no illegal flag. It also pairs a read with a write in one cycle and checks that the read returns the register contents from before the write.

// File: rtl/vblk_ctx_pkg.sv
package vblk_ctx_pkg;
  typedef enum logic [1:0] {
    ST_SCALAR = 2'b00,
    ST_HDR    = 2'b01,
    ST_LEN    = 2'b10,
    ST_RUN    = 2'b11
  } vstat_e;
endpackage

// File: rtl/vblk_csr_chk.sv
module vblk_csr_chk
  import vblk_ctx_pkg::*;
#(
  parameter int XLEN  = 16,
  parameter int IMM_W = 5,
  localparam int PTR_W = XLEN - 2
) (
  input  vstat_e             status_i,
  input  logic               csr_wr_i,
  input  logic               csr_imm_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic [PTR_W-1:0]   blk_len_i,
  output logic               wr_ok_o,
  output logic               wr_bad_o,
  output logic [PTR_W-1:0]   wr_val_o
);
  logic [XLEN-1:0] imm_val;
  logic [XLEN-1:0] cand;
  logic [XLEN-1:0] bound;

  generate
    if (IMM_W < XLEN) begin : g_imm_ext
      assign imm_val = {{(XLEN-IMM_W){1'b0}}, csr_wdata_i[IMM_W-1:0]};
    end else begin : g_imm_full
      assign imm_val = csr_wdata_i;
    end
  endgenerate

  assign bound = {2'b00, blk_len_i};

  always_comb begin
    cand     = csr_imm_i ? imm_val : csr_wdata_i;
    wr_val_o = cand[PTR_W-1:0];
    wr_ok_o  = csr_wr_i && (status_i == ST_RUN) && (cand < bound);
    wr_bad_o = csr_wr_i && !wr_ok_o;
  end
endmodule

// File: rtl/vblk_seq.sv
module vblk_seq
  import vblk_ctx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ev_start_i,
  input  logic   ev_hdr_i,
  input  logic   ev_len_i,
  input  logic   ev_ctx_i,
  input  logic   ev_done_i,
  input  logic   wrap_i,
  input  logic   trap_enter_i,
  input  logic   trap_ret_i,
  output vstat_e status_o,
  output logic   run_ok_o
);
  vstat_e status_q, status_d;
  logic   armed_q, armed_d;
  logic   in_trap_q;

  always_comb begin
    status_d = status_q;
    armed_d  = armed_q;
    if (ev_done_i || wrap_i) begin
      status_d = ST_SCALAR;
      armed_d  = 1'b0;
    end else begin
      unique case (status_q)
        ST_SCALAR: begin
          if (armed_q && ev_hdr_i) begin
            status_d = ST_HDR;
            armed_d  = 1'b0;
          end else if (ev_start_i) begin
            armed_d = 1'b1;
          end
        end
        ST_HDR: if (ev_len_i) status_d = ST_LEN;
        ST_LEN: if (ev_ctx_i) status_d = ST_RUN;
        ST_RUN: if (trap_ret_i) status_d = ST_LEN;
        default: status_d = ST_SCALAR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= ST_SCALAR;
      armed_q   <= 1'b0;
      in_trap_q <= 1'b0;
    end else begin
      status_q <= status_d;
      armed_q  <= armed_d;
      if (trap_enter_i)    in_trap_q <= 1'b1;
      else if (trap_ret_i) in_trap_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign run_ok_o = (status_q == ST_RUN) && !in_trap_q;

  a_r2_leave_scalar_one_step: assert property (@(posedge clk) disable iff (rst)
    status_q == ST_SCALAR |=> status_q inside {ST_SCALAR, ST_HDR});
  a_r3_hdr_needs_start: assert property (@(posedge clk) disable iff (rst)
    (status_q == ST_SCALAR && !armed_q) |=> status_q == ST_SCALAR);
  a_r5_done_clears_status: assert property (@(posedge clk) disable iff (rst)
    ev_done_i |=> status_q == ST_SCALAR);
  a_r10_trap_rollback: assert property (@(posedge clk) disable iff (rst)
    (status_q == ST_RUN && trap_ret_i && !ev_done_i && !wrap_i) |=> status_q == ST_LEN);
endmodule

// File: rtl/vblk_ptr.sv
module vblk_ptr #(
  parameter int PTR_W  = 14,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PTR_W-1:0]  blk_len_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              csr_wr_i,
  input  logic              run_ok_i,
  input  logic              wr_ok_i,
  input  logic [PTR_W-1:0]  wr_val_i,
  input  logic              done_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              wrap_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W:0]   sum;
  logic             adv_eff;

  assign adv_eff = adv_i && run_ok_i && !csr_wr_i;
  assign sum     = {1'b0, ptr_q} + {{(PTR_W+1-STEP_W){1'b0}}, step_i};
  assign wrap_o  = adv_eff && (sum >= {1'b0, blk_len_i});

  always_ff @(posedge clk) begin
    if (rst || done_i || wrap_o) ptr_q <= '0;
    else if (wr_ok_i)            ptr_q <= wr_val_i;
    else if (adv_eff)            ptr_q <= sum[PTR_W-1:0];
  end

  assign ptr_o = ptr_q;

  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_ok_i && !done_i) |=> ptr_q == $past(wr_val_i));
  a_r11_hold_when_blocked: assert property (@(posedge clk) disable iff (rst)
    (!run_ok_i && !wr_ok_i && !done_i) |=> $stable(ptr_q));
  a_r4_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> ptr_q == '0);
endmodule

// File: rtl/vblk_ctx.sv
module vblk_ctx
  import vblk_ctx_pkg::*;
#(
  parameter int XLEN   = 16,
  parameter int IMM_W  = 5,
  parameter int STEP_W = 3,
  localparam int PTR_W = XLEN - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_start_i,
  input  logic              ev_hdr_i,
  input  logic              ev_len_i,
  input  logic              ev_ctx_i,
  input  logic              ev_done_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [PTR_W-1:0]  blk_len_i,
  input  logic              trap_enter_i,
  input  logic              trap_ret_i,
  input  logic              csr_rd_i,
  input  logic              csr_wr_i,
  input  logic              csr_imm_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [1:0]        status_o,
  output logic [PTR_W-1:0]  opptr_o,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              illegal_o
);
  vstat_e           status;
  logic             run_ok, wrap;
  logic             wr_ok, wr_bad;
  logic [PTR_W-1:0] wr_val, ptr;
  logic [XLEN-1:0]  rdata_q;
  logic             illegal_q;

  vblk_seq u_seq (
    .clk(clk), .rst(rst),
    .ev_start_i(ev_start_i), .ev_hdr_i(ev_hdr_i), .ev_len_i(ev_len_i),
    .ev_ctx_i(ev_ctx_i), .ev_done_i(ev_done_i), .wrap_i(wrap),
    .trap_enter_i(trap_enter_i), .trap_ret_i(trap_ret_i),
    .status_o(status), .run_ok_o(run_ok)
  );

  vblk_csr_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
    .status_i(status), .csr_wr_i(csr_wr_i), .csr_imm_i(csr_imm_i),
    .csr_wdata_i(csr_wdata_i), .blk_len_i(blk_len_i),
    .wr_ok_o(wr_ok), .wr_bad_o(wr_bad), .wr_val_o(wr_val)
  );

  vblk_ptr #(.PTR_W(PTR_W), .STEP_W(STEP_W)) u_ptr (
    .clk(clk), .rst(rst), .blk_len_i(blk_len_i),
    .adv_i(adv_i), .step_i(step_i), .csr_wr_i(csr_wr_i),
    .run_ok_i(run_ok), .wr_ok_i(wr_ok), .wr_val_i(wr_val),
    .done_i(ev_done_i), .ptr_o(ptr), .wrap_o(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (csr_rd_i) rdata_q <= {ptr, status};
      illegal_q <= wr_bad;
    end
  end

  assign status_o    = status;
  assign opptr_o     = ptr;
  assign csr_rdata_o = rdata_q;
  assign illegal_o   = illegal_q;

  a_r8_flag_raised: assert property (@(posedge clk) disable iff (rst)
    wr_bad |=> illegal_o);
  a_r8_state_kept: assert property (@(posedge clk) disable iff (rst)
    (wr_bad && !ev_done_i && !trap_ret_i && !adv_i) |=> ($stable(status_o) && $stable(opptr_o)));
  a_r9_read_full: assert property (@(posedge clk) disable iff (rst)
    csr_rd_i |=> csr_rdata_o == {$past(opptr_o), $past(status_o)});
endmodule

// File: tb/vblk_ctx_test.sv
module vblk_ctx_test;
  localparam int XLEN = 16;
  localparam int PTR_W = XLEN - 2;
  localparam int STEP_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_start, ev_hdr, ev_len, ev_ctx, ev_done, adv;
  logic [STEP_W-1:0] step;
  logic [PTR_W-1:0] blk_len;
  logic trap_enter, trap_ret, csr_rd, csr_wr, csr_imm;
  logic [XLEN-1:0] wdata;
  logic [1:0] status;
  logic [PTR_W-1:0] opptr;
  logic [XLEN-1:0] rdata;
  logic illegal;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vblk_ctx #(.XLEN(XLEN), .IMM_W(5), .STEP_W(STEP_W)) uut (
    .clk(clk), .rst(rst),
    .ev_start_i(ev_start), .ev_hdr_i(ev_hdr), .ev_len_i(ev_len),
    .ev_ctx_i(ev_ctx), .ev_done_i(ev_done), .adv_i(adv), .step_i(step),
    .blk_len_i(blk_len), .trap_enter_i(trap_enter), .trap_ret_i(trap_ret),
    .csr_rd_i(csr_rd), .csr_wr_i(csr_wr), .csr_imm_i(csr_imm),
    .csr_wdata_i(wdata), .status_o(status), .opptr_o(opptr),
    .csr_rdata_o(rdata), .illegal_o(illegal)
  );

  typedef struct packed {
    logic st, hd, ln, cx, dn, ad;
    logic [2:0] stp;
    logic wr, im;
    logic [15:0] wd;
    logic [1:0] est;
    logic [13:0] eptr;
    logic eill;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd0,14'd0, 1'b0}, // R3 hdr w/o start
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd0,14'd0, 1'b0}, // R2 arm
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd1,14'd0, 1'b0}, // R2 -> 1
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd1,14'd0, 1'b0}, // R3 ctx early
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd2,14'd0, 1'b0}, // R2 -> 2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,16'd3,    2'd2,14'd0, 1'b1}, // R8 write in 2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,1'b0,16'd0,    2'd3,14'd0, 1'b0}, // R2 -> 3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd2,1'b0,1'b0,16'd0,    2'd3,14'd2, 1'b0}, // R4 adv 2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,16'h0047, 2'd3,14'd7, 1'b0}, // R6 imm low bits
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,16'd25,   2'd3,14'd7, 1'b1}, // R7 out of range
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,16'd19,   2'd3,14'd19,1'b0}, // R7 last legal
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,16'd20,   2'd3,14'd19,1'b1}, // R7 bound
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b1,1'b1,16'd5,    2'd3,14'd5, 1'b0}, // R12 write beats adv
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd3,1'b0,1'b0,16'd0,    2'd3,14'd8, 1'b0}, // R4 adv 3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,16'h8012, 2'd3,14'd8, 1'b1}, // R7 upper bit set
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,16'd18,   2'd3,14'd18,1'b0}, // R7 write 18
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,16'd0,    2'd3,14'd19,1'b0}, // R4 to last
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,1'b0,1'b0,16'd0,    2'd0,14'd0, 1'b0}  // R4 wrap
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ev_start = 0; ev_hdr = 0; ev_len = 0; ev_ctx = 0; ev_done = 0; adv = 0;
    step = '0; trap_enter = 0; trap_ret = 0; csr_rd = 0; csr_wr = 0;
    csr_imm = 0; wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic expect_st(input string tag, input int st, input int p, input logic ill);
    chk({tag, " status"}, status, st);
    chk({tag, " ptr"}, opptr, p);
    chk({tag, " illegal"}, illegal, ill);
  endtask

  task automatic enter_run();
    ev_start = 1; tick();
    ev_hdr = 1; tick();
    ev_len = 1; tick();
    ev_ctx = 1; tick();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    blk_len = 14'd20;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    expect_st("R1 reset", 0, 0, 1'b0);
    chk("R1 rdata", rdata, 0);

    for (int i = 0; i < NV; i++) begin
      ev_start = TBL[i].st; ev_hdr = TBL[i].hd; ev_len = TBL[i].ln;
      ev_ctx = TBL[i].cx; ev_done = TBL[i].dn; adv = TBL[i].ad;
      step = TBL[i].stp; csr_wr = TBL[i].wr; csr_imm = TBL[i].im;
      wdata = TBL[i].wd;
      tick();
      expect_st($sformatf("vec%0d", i), TBL[i].est, TBL[i].eptr, TBL[i].eill);
    end

    // R9 read with same-cycle write returns old register
    enter_run();
    csr_wr = 1; wdata = 16'd6; tick();
    csr_rd = 1; csr_wr = 1; wdata = 16'd9; tick();
    chk("R9 rdata old value", rdata, 6*4 + 3);
    chk("R9 ptr after write", opptr, 9);

    // R11 advance ignored during trap; R10 rollback keeps pointer
    trap_enter = 1; tick();
    adv = 1; step = 3'd2; tick();
    expect_st("R11 trap adv", 3, 9, 1'b0);
    trap_ret = 1; tick();
    expect_st("R10 rollback", 2, 9, 1'b0);
    ev_ctx = 1; tick();
    expect_st("R10 reenter", 3, 9, 1'b0);
    adv = 1; step = 3'd1; tick();
    expect_st("R11 adv after ret", 3, 10, 1'b0);
    csr_rd = 1; tick();
    chk("R9 rdata full", rdata, 10*4 + 3);

    // R5 done beats a legal write
    ev_done = 1; csr_wr = 1; wdata = 16'd4; tick();
    expect_st("R5 done+write", 0, 0, 1'b0);

    // R5 done from status 1
    ev_start = 1; tick();
    ev_hdr = 1; tick();
    expect_st("R2 hdr again", 1, 0, 1'b0);
    ev_done = 1; tick();
    expect_st("R5 done from hdr", 0, 0, 1'b0);

    // R1 reset from running state
    enter_run();
    csr_wr = 1; wdata = 16'd5; tick();
    rst = 1; tick();
    rst = 0;
    expect_st("R1 reset mid-block", 0, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule